// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

This block is a word-oriented serial port for a processor. Each direction has its own holding register. On the transmit side, the CPU writes a word into a holding register. The word moves into a shift register as soon as that shift register is empty. It then leaves MSB first on a serial clock that the block generates, and a frame pulse marks the first bit. On the receive side, an external serial clock and frame pulse clock bits into a receive shift register. A complete word is handed to a holding register that the CPU reads.

Each direction has a ready flag. A rising edge of a ready flag raises an interrupt flag, but only when both the port-level enable and the CPU-level enable for that direction are set. If the receive holding register has not been read when the next word completes, the receiver stops. It keeps that word in its shift register and ignores further input until the CPU reads. The word length and the serial clock rate are parameters.

The CPU port is a small register file addressed by `addr`:
- 0: transmit data, write only.
- 1: receive data, read only.
- 2: control, read and write. Bit 0 is the port transmit enable, bit 1 the CPU transmit enable, bit 2 the port receive enable, bit 3 the CPU receive enable.
- 3: status. Bit 0 is tx-ready, bit 1 rx-ready, bit 2 the transmit interrupt flag, bit 3 the receive interrupt flag. Bits 2 and 3 are cleared by writing 1 to them.

Top module: `sync_serial_port`

## Requirements
- R1: A write to address 0 stores the word and clears tx-ready (status bit 0 reads 0 in the next cycle).
- R2: A stored word moves into the transmit shift register only on a serial bit boundary when that register is empty. tx-ready sets at that moment. A word waiting at the end of a transfer follows with no idle bit between frames.
- R3: `txData` is shifted MSB first and changes only when `txClk` falls. `txClk` has a half period of CLK_DIV clock cycles. `txFrame` is high for exactly the first bit period of each word.
- R4: A rising edge of `rxClk` with `rxFrame` high starts a word, and that bit is its MSB. After WORD_W bits the word is copied to the receive holding register and rx-ready sets. `rxClk` edges with no frame and no word in progress have no effect.
- R5: A read of address 1 returns the received word and clears rx-ready.
- R6: A word that completes while rx-ready is set is kept in the shift register, and the holding register is not changed. Later input bits are ignored. A read of address 1 then moves the kept word into the holding register and sets rx-ready again. A word that arrives while the receiver is stopped is lost.
- R7: The transmit interrupt flag (status bit 2, `txIrq`) sets on a rising edge of tx-ready only when control bits 0 and 1 are both 1.
- R8: The receive interrupt flag (status bit 3, `rxIrq`) sets on a rising edge of rx-ready only when control bits 2 and 3 are both 1.
- R9: Interrupt flags stay set until 1 is written to their status bit. Writing 0 leaves them unchanged.
- R10: After reset, status reads 0x1 (tx-ready only), `txFrame`, `txIrq` and `rxIrq` are 0, and control reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (has side effects at address 1) |
| addr | input | 2 | Register address |
| wrData | input | WORD_W | Write data |
| rdData | output | WORD_W | Read data, combinational from addr |
| txClk | output | 1 | Generated serial clock |
| txFrame | output | 1 | Transmit frame pulse |
| txData | output | 1 | Serial transmit data |
| rxClk | input | 1 | Receive serial clock, synchronous to clk |
| rxFrame | input | 1 | Receive frame pulse |
| rxData | input | 1 | Serial receive data |
| txIrq | output | 1 | Transmit interrupt flag |
| rxIrq | output | 1 | Receive interrupt flag |

## Verification
Some rules are checked by assertions on every cycle:
- tx-ready clears after a write.
- tx-ready rises and the frame pulse starts together with a load.
- A load puts the holding MSB on the data line.
- The receive holding register does not change while rx-ready is set.
- A read clears rx-ready.
- Each interrupt flag follows its gated ready edge and its write-1 clear.

Other behaviours can only be shown by the bench's scenarios:
- Whole words survive the loopback.
- The stopped receiver keeps the second word and drops the third.
- Frames without a frame pulse are ignored.
- The frame pulse has the correct width.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [1:0] ADDR_TX  = 2'd0;
  localparam logic [1:0] ADDR_RX  = 2'd1;
  localparam logic [1:0] ADDR_CTL = 2'd2;
  localparam logic [1:0] ADDR_STS = 2'd3;

  typedef struct packed {
    logic wrHold;   // capture CPU word into transmit holding
    logic loadTx;   // holding -> transmit shifter
    logic shiftTx;  // advance transmit shifter by one bit
    logic shiftRx;  // take one receive bit
    logic xferRx;   // receive shifter -> receive holding
  } sspStrobe_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl import ssp_pkg::*; #(
  parameter int WORD_W  = 16,
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [3:0] wrLow,
  input  logic       rxClk,
  input  logic       rxFrame,
  output sspStrobe_t st,
  output logic       txClk,
  output logic       txFrame,
  output logic       txReady,
  output logic       rxReady,
  output logic       txIntFlag,
  output logic       rxIntFlag,
  output logic [3:0] ctl
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam int DIV_W = $clog2(CLK_DIV + 1);

  logic [DIV_W-1:0] divCnt;
  logic             txClkR, wrap, fallTick;
  logic             holdFull, txBusy, txFrameR;
  logic [CNT_W-1:0] txCnt, rxCnt;
  logic             rxClkPrev, rxClkRise, rxActive, rxPend, rxReadyR;
  logic             txReadyPrev, rxReadyPrev, txSet, rxSet;
  logic             wrTx, rdRx, wrCtl, wrSts;

  assign wrTx  = wrEn && addr == ADDR_TX;
  assign rdRx  = rdEn && addr == ADDR_RX;
  assign wrCtl = wrEn && addr == ADDR_CTL;
  assign wrSts = wrEn && addr == ADDR_STS;

  // serial clock generator
  assign wrap     = divCnt == DIV_W'(CLK_DIV - 1);
  assign fallTick = wrap && txClkR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
      txClkR <= 1'b0;
    end else begin
      divCnt <= wrap ? '0 : divCnt + 1'b1;
      if (wrap) txClkR <= ~txClkR;
    end
  end

  // transmit sequencing
  assign st.wrHold  = wrTx;
  assign st.loadTx  = fallTick && holdFull && (!txBusy || txCnt == '0);
  assign st.shiftTx = fallTick && txBusy && txCnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdFull <= 1'b0;
      txBusy   <= 1'b0;
      txCnt    <= '0;
      txFrameR <= 1'b0;
    end else begin
      if (wrTx)           holdFull <= 1'b1;
      else if (st.loadTx) holdFull <= 1'b0;
      if (st.loadTx) begin
        txBusy   <= 1'b1;
        txCnt    <= CNT_W'(WORD_W - 1);
        txFrameR <= 1'b1;
      end else if (fallTick) begin
        txFrameR <= 1'b0;
        if (txBusy) begin
          if (txCnt != '0) txCnt  <= txCnt - 1'b1;
          else             txBusy <= 1'b0;
        end
      end
    end
  end

  // receive sequencing
  assign rxClkRise = rxClk && !rxClkPrev;
  assign st.shiftRx = rxClkRise && !rxPend && (rxActive || rxFrame);
  assign st.xferRx  = rxPend && !rxReadyR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxClkPrev <= 1'b0;
      rxActive  <= 1'b0;
      rxCnt     <= '0;
      rxPend    <= 1'b0;
      rxReadyR  <= 1'b0;
    end else begin
      rxClkPrev <= rxClk;
      if (st.shiftRx) begin
        if (!rxActive) begin
          rxActive <= 1'b1;
          rxCnt    <= CNT_W'(WORD_W - 2);
        end else if (rxCnt == '0) begin
          rxActive <= 1'b0;
          rxPend   <= 1'b1;
        end else begin
          rxCnt <= rxCnt - 1'b1;
        end
      end else if (st.xferRx) begin
        rxPend <= 1'b0;
      end
      if (st.xferRx)  rxReadyR <= 1'b1;
      else if (rdRx)  rxReadyR <= 1'b0;
    end
  end

  // interrupt flags and control
  assign txSet = txReady && !txReadyPrev && ctl[0] && ctl[1];
  assign rxSet = rxReadyR && !rxReadyPrev && ctl[2] && ctl[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txReadyPrev <= 1'b1;
      rxReadyPrev <= 1'b0;
      txIntFlag   <= 1'b0;
      rxIntFlag   <= 1'b0;
      ctl         <= '0;
    end else begin
      txReadyPrev <= txReady;
      rxReadyPrev <= rxReadyR;
      txIntFlag   <= txSet || (txIntFlag && !(wrSts && wrLow[2]));
      rxIntFlag   <= rxSet || (rxIntFlag && !(wrSts && wrLow[3]));
      if (wrCtl) ctl <= wrLow;
    end
  end

  assign txReady = !holdFull;
  assign rxReady = rxReadyR;
  assign txClk   = txClkR;
  assign txFrame = txFrameR;

  assert_write_clears_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wrTx |=> !txReady);
  assert_load_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st.loadTx && !wrTx) |=> (txReady && txFrame));
  assert_xfer_sets_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st.xferRx |=> rxReady);
  assert_read_clears_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdRx && rxReady) |=> !rxReady);
  assert_tx_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(txReady) && ctl[0] && ctl[1]) |=> txIntFlag);
  assert_rx_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rxReady) && ctl[2] && ctl[3]) |=> rxIntFlag);
  assert_w1c_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wrSts && wrLow[2] && !txSet) |=> !txIntFlag);
  assert_sticky_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rxIntFlag && !(wrSts && wrLow[3])) |=> rxIntFlag);
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath import ssp_pkg::*; #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sspStrobe_t        st,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rxBit,
  input  logic [1:0]        addr,
  input  logic [3:0]        ctl,
  input  logic              txReady,
  input  logic              rxReady,
  input  logic              txIntFlag,
  input  logic              rxIntFlag,
  output logic              txBit,
  output logic [WORD_W-1:0] rdData
);
  localparam int PAD_W = WORD_W - 4;

  logic [WORD_W-1:0] holdTx, txSr, rxSr, rxHold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdTx <= '0;
      txSr   <= '0;
      rxSr   <= '0;
      rxHold <= '0;
    end else begin
      if (st.wrHold)       holdTx <= wrData;
      if (st.loadTx)       txSr   <= holdTx;
      else if (st.shiftTx) txSr   <= {txSr[WORD_W-2:0], 1'b0};
      if (st.shiftRx)      rxSr   <= {rxSr[WORD_W-2:0], rxBit};
      if (st.xferRx)       rxHold <= rxSr;
    end
  end

  assign txBit = txSr[WORD_W-1];

  always_comb begin
    unique case (addr)
      ADDR_RX:  rdData = rxHold;
      ADDR_CTL: rdData = {{PAD_W{1'b0}}, ctl};
      ADDR_STS: rdData = {{PAD_W{1'b0}}, rxIntFlag, txIntFlag, rxReady, txReady};
      default:  rdData = '0;
    endcase
  end

  assert_msb_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st.loadTx |=> (txBit == $past(holdTx[WORD_W-1])));
  assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rxReady |=> $stable(rxHold));
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port import ssp_pkg::*; #(
  parameter int WORD_W  = 16,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              txClk,
  output logic              txFrame,
  output logic              txData,
  input  logic              rxClk,
  input  logic              rxFrame,
  input  logic              rxData,
  output logic              txIrq,
  output logic              rxIrq
);
  sspStrobe_t st;
  logic       txReady, rxReady, txIntFlag, rxIntFlag;
  logic [3:0] ctl;

  ssp_ctrl #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrLow(wrData[3:0]), .rxClk(rxClk), .rxFrame(rxFrame), .st(st),
    .txClk(txClk), .txFrame(txFrame), .txReady(txReady), .rxReady(rxReady),
    .txIntFlag(txIntFlag), .rxIntFlag(rxIntFlag), .ctl(ctl)
  );

  ssp_datapath #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .st(st), .wrData(wrData), .rxBit(rxData),
    .addr(addr), .ctl(ctl), .txReady(txReady), .rxReady(rxReady),
    .txIntFlag(txIntFlag), .rxIntFlag(rxIntFlag), .txBit(txData), .rdData(rdData)
  );

  assign txIrq = txIntFlag;
  assign rxIrq = rxIntFlag;
endmodule

// File: tb/sync_serial_port_tb_top.sv
module sync_serial_port_tb_top;
  localparam int W   = 16;
  localparam int DIV = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [W-1:0] wrData = '0, rdData;
  logic txClk, txFrame, txData, txIrq, rxIrq;
  logic rxClk, rxFrame, rxData;
  logic loopSel = 1'b1, extClk = 1'b0, extFrame = 1'b0, extData = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] monWords [0:63];
  int monCount = 0, monBits = 0;
  logic [W-1:0] monAcc = '0;
  int frameLen = 0, lastFrameLen = 0;

  always #2.5 clk = ~clk;

  assign rxClk   = loopSel ? txClk   : extClk;
  assign rxFrame = loopSel ? txFrame : extFrame;
  assign rxData  = loopSel ? txData  : extData;

  sync_serial_port #(.WORD_W(W), .CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .txClk(txClk), .txFrame(txFrame),
    .txData(txData), .rxClk(rxClk), .rxFrame(rxFrame), .rxData(rxData),
    .txIrq(txIrq), .rxIrq(rxIrq)
  );

  // independent serial decoder on the transmit pins
  always @(posedge txClk) begin
    if (txFrame) begin
      monAcc  = {{(W-1){1'b0}}, txData};
      monBits = 1;
    end else if (monBits > 0) begin
      monAcc  = {monAcc[W-2:0], txData};
      monBits = monBits + 1;
    end
    if (monBits == W) begin
      monWords[monCount % 64] = monAcc;
      monCount = monCount + 1;
      monBits  = 0;
    end
  end

  always @(negedge clk) begin
    if (txFrame) frameLen <= frameLen + 1;
    else if (frameLen != 0) begin
      lastFrameLen <= frameLen;
      frameLen     <= 0;
    end
  end

  function automatic logic [W-1:0] expStatus(bit txr, bit rxr, bit ti, bit ri);
    return {{(W-4){1'b0}}, ri, ti, rxr, txr};
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(logic [1:0] a, logic [W-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cpuRead(logic [1:0] a, output logic [W-1:0] d);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitStatus(int bitIdx, output bit seen);
    logic [W-1:0] s;
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      cpuRead(2'd3, s);
      seen = s[bitIdx];
    end
  endtask

  task automatic sendTx(logic [W-1:0] w);
    bit ok;
    waitStatus(0, ok);
    cpuWrite(2'd0, w);
  endtask

  task automatic recvWord(string req, logic [W-1:0] exp);
    bit ok;
    logic [W-1:0] got;
    waitStatus(1, ok);
    check(ok, req, {{(W-1){1'b0}}, ok}, 1);
    cpuRead(2'd1, got);
    check(got == exp, req, got, exp);
  endtask

  task automatic sendExt(logic [W-1:0] w, bit withFrame);
    for (int i = W - 1; i >= 0; i--) begin
      @(negedge clk);
      extData  = w[i];
      extFrame = withFrame && (i == W - 1);
      repeat (3) @(negedge clk);
      extClk = 1'b1;
      repeat (3) @(negedge clk);
      extClk = 1'b0;
    end
    extFrame = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] r, w1, w2, w3;
    bit ok;
    int base;
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    cpuRead(2'd3, r);
    check(r == expStatus(1, 0, 0, 0), "R10 status", r, expStatus(1, 0, 0, 0));
    cpuRead(2'd2, r);
    check(r == '0, "R10 control", r, '0);
    check({txFrame, txIrq, rxIrq} == 3'b000, "R10 outputs", {13'd0, txFrame, txIrq, rxIrq}, 0);

    // R1, R2, R3: write, ready handshake, back-to-back frames
    base = monCount;
    cpuWrite(2'd0, 16'hC3A5);
    cpuRead(2'd3, r);
    check(r[0] == 1'b0, "R1 ready cleared", r, expStatus(0, 0, 0, 0));
    waitStatus(0, ok);
    check(ok, "R2 ready after load", {15'd0, ok}, 1);
    cpuWrite(2'd0, 16'h5A3C);
    recvWord("R4 loopback first", 16'hC3A5);
    recvWord("R2 back-to-back second", 16'h5A3C);
    check(monWords[base % 64] == 16'hC3A5, "R3 msb first", monWords[base % 64], 16'hC3A5);
    check(monWords[(base + 1) % 64] == 16'h5A3C, "R3 second word", monWords[(base + 1) % 64], 16'h5A3C);
    check(lastFrameLen == 2 * DIV, "R3 frame width", lastFrameLen[W-1:0], 2 * DIV);

    // random loopback words
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] rw;
      rw = W'($urandom);
      base = monCount;
      sendTx(rw);
      recvWord("R4 random loopback", rw);
      check(monWords[base % 64] == rw, "R3 random serial", monWords[base % 64], rw);
    end

    // R6 freeze: three words, no reads in between
    w1 = 16'h1111; w2 = 16'h2222; w3 = 16'h3333;
    base = monCount;
    sendTx(w1); sendTx(w2); sendTx(w3);
    while (monCount < base + 3) @(negedge clk);
    repeat (20) @(negedge clk);
    cpuRead(2'd1, r);
    check(r == w1, "R6 holding kept first", r, w1);
    waitStatus(1, ok);
    check(ok, "R6 release sets ready", {15'd0, ok}, 1);
    cpuRead(2'd1, r);
    check(r == w2, "R6 kept second word", r, w2);
    repeat (100) @(negedge clk);
    cpuRead(2'd3, r);
    check(r[1] == 1'b0, "R6 third word dropped", r, expStatus(1, 0, 0, 0));

    // R4 external clock, frameless bits ignored
    loopSel = 1'b0;
    sendExt(16'hFFFF, 0);
    repeat (5) @(negedge clk);
    cpuRead(2'd3, r);
    check(r[1] == 1'b0, "R4 no frame ignored", r, expStatus(1, 0, 0, 0));
    sendExt(16'h9E27, 1);
    recvWord("R4 external word", 16'h9E27);
    loopSel = 1'b1;

    // R7, R8, R9 interrupts
    cpuWrite(2'd3, 16'h000C);
    cpuWrite(2'd2, 16'h000F);
    sendTx(16'h0F0F);
    waitStatus(0, ok);
    @(negedge clk);
    check(txIrq == 1'b1, "R7 tx irq set", {15'd0, txIrq}, 1);
    waitStatus(1, ok);
    @(negedge clk);
    check(rxIrq == 1'b1, "R8 rx irq set", {15'd0, rxIrq}, 1);
    cpuRead(2'd1, r);
    check(r == 16'h0F0F, "R5 read word", r, 16'h0F0F);
    cpuRead(2'd3, r);
    check(r[1] == 1'b0, "R5 read clears ready", r, expStatus(1, 0, 1, 1));
    cpuWrite(2'd3, 16'h0000);
    cpuRead(2'd3, r);
    check(r[3:2] == 2'b11, "R9 zero write keeps", r, expStatus(1, 0, 1, 1));
    cpuWrite(2'd3, 16'h0004);
    cpuRead(2'd3, r);
    check(r[3:2] == 2'b10, "R9 clear tx only", r, expStatus(1, 0, 0, 1));
    cpuWrite(2'd3, 16'h0008);
    cpuRead(2'd3, r);
    check(r[3:2] == 2'b00, "R9 clear rx", r, expStatus(1, 0, 0, 0));

    // gating: port enables only, CPU-level enables off
    cpuWrite(2'd2, 16'h0005);
    sendTx(16'h7711);
    recvWord("R4 gated loopback", 16'h7711);
    repeat (4) @(negedge clk);
    check(txIrq == 1'b0, "R7 gated off", {15'd0, txIrq}, 0);
    check(rxIrq == 1'b0, "R8 gated off", {15'd0, rxIrq}, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule